// File: doc/BRIEF.md
# Motor Control PWM Channel

This block is one pulse-width modulation channel for a motor drive stage. It holds its own timer-counter, a period value and a match value. From the comparison of the counter with the match value it drives a complementary pair of outputs, A and B, for the high-side and low-side switches of one half-bridge. The counter either ramps up and wraps (edge-aligned) or ramps up and back down (center-aligned).

Software writes the period and match values into write registers. The counter compares against separate functional registers. While the timer runs, the functional registers are refreshed from the write registers only when a PWM cycle ends, and a freeze control can block that refresh entirely. While the timer is stopped, writes reach the functional registers at once and both outputs sit at their passive level.

Optional dead time delays every passive-to-active edge on either output by a programmable number of clocks, so the two switches of the bridge are never on together. A polarity control picks whether the active level at the pins is high or low.

Top module: `motor_pwm_chan`

## Requirements
- R1: With `run_i` low the counter is held at 0 and both outputs show their passive level. With `run_i` high the counter advances one step per clock.
- R2: With `center_i` = 0 (edge-aligned) the counter steps 0,1,…,P and then returns to 0, giving a cycle of P+1 clocks. A is active on counts that are at least the match value M, which gives P−M+1 active clocks per cycle.
- R3: With `center_i` = 1 (center-aligned) the counter steps up from 0 to P and back down to 1, giving a cycle of 2P clocks. A is active on counts ≥ M, which gives 2(P−M)+1 active clocks per cycle. The cycle ends on the return to 0.
- R4: While running, B is active exactly on the counts where A's compare is passive (count < M), before any dead time is applied.
- R5: `pol_i` = 0 drives active as 1 and passive as 0 on both pins. `pol_i` = 1 drives active as 0 and passive as 1.
- R6: With `dt_en_i` = 1, each passive-to-active edge on A and on B is delayed by `dt_val_i` clocks, and active-to-passive edges are not delayed. A and B are never active in the same clock.
- R7: With `upd_dis_i` = 0 and the timer running, a value written by `per_we_i` or `mat_we_i` takes effect only at the next end of a PWM cycle.
- R8: With `upd_dis_i` = 1 and the timer running, the functional period and match values do not change.
- R9: While `run_i` is low, a write updates the functional period or match value on the next clock, whatever the state of `upd_dis_i`.
- R10: After reset the timer is stopped, the period and match values are 0, and both outputs are passive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 runs the timer, 0 stops it |
| center_i | input | 1 | 0 edge-aligned, 1 center-aligned |
| pol_i | input | 1 | 0 active-high pins, 1 active-low pins |
| dt_en_i | input | 1 | Enables dead-time insertion |
| upd_dis_i | input | 1 | 1 freezes functional registers while running |
| per_we_i | input | 1 | Write strobe for the period write register |
| mat_we_i | input | 1 | Write strobe for the match write register |
| wdata_i | input | CNT_W | Write data for period or match |
| dt_val_i | input | DT_W | Dead-time length in clocks |
| out_a_o | output | 1 | Output A pin level |
| out_b_o | output | 1 | Output B pin level |

## Verification
The assertions assume that the alignment mode is not switched mid-cycle in a way that leaves the counter above the functional period. They rely on functional registers changing only through a write or an end-of-cycle load. The stimulus changes alignment, polarity and dead-time settings only while `run_i` is low, and it always programs a match value no larger than the period when a vector expects both outputs to toggle. Dead time is measured only on vectors whose active runs are longer than the dead time, so the active counts per cycle shrink by exactly the dead-time length.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;
  localparam int unsigned NUM_OUT = 2;  // index 0: A, 1: B
endpackage

// File: rtl/motor_pwm_regs.sv
module motor_pwm_regs #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             upd_dis_i,
  input  logic             eoc_i,
  input  logic             per_we_i,
  input  logic             mat_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] per_f_o,
  output logic [CNT_W-1:0] mat_f_o
);
  logic [CNT_W-1:0] per_w_q, mat_w_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_w_q <= '0;
      mat_w_q <= '0;
      per_f_o <= '0;
      mat_f_o <= '0;
    end else begin
      if (per_we_i) per_w_q <= wdata_i;
      if (mat_we_i) mat_w_q <= wdata_i;
      if (!run_i) begin
        // stopped: writes bypass the shadow
        if (per_we_i) per_f_o <= wdata_i;
        if (mat_we_i) mat_f_o <= wdata_i;
      end else if (eoc_i && !upd_dis_i) begin
        per_f_o <= per_w_q;
        mat_f_o <= mat_w_q;
      end
    end
  end
endmodule

// File: rtl/motor_pwm_counter.sv
module motor_pwm_counter
  import motor_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eoc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_dir_e         dir_q, dir_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o;
    dir_d = dir_q;
    eoc_o = 1'b0;
    if (!run_i) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (!center_i) begin
      dir_d = DIR_UP;
      if (cnt_o >= per_i) begin
        cnt_d = '0;
        eoc_o = 1'b1;
      end else begin
        cnt_d = cnt_o + ONE;
      end
    end else if (dir_q == DIR_UP) begin
      if (cnt_o >= per_i) begin
        if (per_i <= ONE) begin
          cnt_d = '0;
          eoc_o = 1'b1;
        end else begin
          cnt_d = per_i - ONE;
          dir_d = DIR_DOWN;
        end
      end else begin
        cnt_d = cnt_o + ONE;
      end
    end else begin
      if (cnt_o <= ONE) begin
        cnt_d = '0;
        dir_d = DIR_UP;
        eoc_o = 1'b1;
      end else begin
        cnt_d = cnt_o - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_o <= cnt_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/motor_pwm_deadtime.sv
module motor_pwm_deadtime #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            raw_i,
  input  logic            dt_en_i,
  input  logic [DT_W-1:0] dt_val_i,
  output logic            act_o
);
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      act_o  <= 1'b0;
    end else if (!dt_en_i) begin
      wait_q <= dt_val_i;
      act_o  <= raw_i;
    end else if (!raw_i) begin
      wait_q <= dt_val_i;
      act_o  <= 1'b0;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - DT_W'(1);
      act_o  <= 1'b0;
    end else begin
      act_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/motor_pwm_chan.sv
module motor_pwm_chan
  import motor_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic             pol_i,
  input  logic             dt_en_i,
  input  logic             upd_dis_i,
  input  logic             per_we_i,
  input  logic             mat_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [DT_W-1:0]  dt_val_i,
  output logic             out_a_o,
  output logic             out_b_o
);
  logic [CNT_W-1:0]   per_f, mat_f, cnt_q;
  logic               eoc, cmp_hit;
  logic [NUM_OUT-1:0] raw, act;

  motor_pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .upd_dis_i (upd_dis_i),
    .eoc_i     (eoc),
    .per_we_i  (per_we_i),
    .mat_we_i  (mat_we_i),
    .wdata_i   (wdata_i),
    .per_f_o   (per_f),
    .mat_f_o   (mat_f)
  );

  motor_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .center_i (center_i),
    .per_i    (per_f),
    .cnt_o    (cnt_q),
    .eoc_o    (eoc)
  );

  assign cmp_hit = (cnt_q >= mat_f);
  assign raw[0]  = run_i &  cmp_hit;
  assign raw[1]  = run_i & ~cmp_hit;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_dt
    motor_pwm_deadtime #(.DT_W(DT_W)) u_dt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .raw_i    (raw[g]),
      .dt_en_i  (dt_en_i),
      .dt_val_i (dt_val_i),
      .act_o    (act[g])
    );
  end

  assign out_a_o = act[0] ^ pol_i;
  assign out_b_o = act[1] ^ pol_i;
endmodule

// File: rtl/motor_pwm_chk.sv
module motor_pwm_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             upd_dis_i,
  input logic             per_we_i,
  input logic             mat_we_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             eoc_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] per_f_i,
  input logic [CNT_W-1:0] mat_f_i,
  input logic [1:0]       act_i
);
  a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_i[0] && act_i[1]));

  a_r1_stop_passive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (act_i == 2'b00));

  a_r1_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_i == '0));

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= per_f_i);

  a_r7_load_at_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !eoc_i) |=> ($stable(per_f_i) && $stable(mat_f_i)));

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && upd_dis_i) |=> ($stable(per_f_i) && $stable(mat_f_i)));

  a_r9_direct_per: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && per_we_i) |=> (per_f_i == $past(wdata_i)));

  a_r9_direct_mat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && mat_we_i) |=> (mat_f_i == $past(wdata_i)));
endmodule

bind motor_pwm_chan motor_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run_i     (run_i),
  .upd_dis_i (upd_dis_i),
  .per_we_i  (per_we_i),
  .mat_we_i  (mat_we_i),
  .wdata_i   (wdata_i),
  .eoc_i     (eoc),
  .cnt_i     (cnt_q),
  .per_f_i   (per_f),
  .mat_f_i   (mat_f),
  .act_i     (act)
);

// File: tb/tb_motor_pwm_chan.sv
module tb_motor_pwm_chan;
  localparam int CNT_W = 16;
  localparam int DT_W  = 8;
  localparam int NVEC  = 7;
  localparam int NPER  = 4;

  typedef struct packed {
    logic        center;
    logic        pol;
    logic        dten;
    logic [15:0] per;
    logic [15:0] mat;
    logic [7:0]  dt;
    logic [15:0] exp_a;  // active A clocks per cycle
    logic [15:0] exp_b;  // active B clocks per cycle
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 16'd9, 16'd4, 8'd0, 16'd6,  16'd4},   // R2 R4
    '{1'b0, 1'b1, 1'b0, 16'd9, 16'd4, 8'd0, 16'd6,  16'd4},   // R5
    '{1'b0, 1'b0, 1'b1, 16'd9, 16'd4, 8'd2, 16'd4,  16'd2},   // R6
    '{1'b1, 1'b0, 1'b0, 16'd8, 16'd3, 8'd0, 16'd11, 16'd5},   // R3
    '{1'b1, 1'b0, 1'b1, 16'd8, 16'd3, 8'd3, 16'd8,  16'd2},   // R3 R6
    '{1'b0, 1'b0, 1'b0, 16'd7, 16'd0, 8'd0, 16'd8,  16'd0},   // R2 match 0
    '{1'b1, 1'b1, 1'b0, 16'd6, 16'd6, 8'd0, 16'd1,  16'd11}   // R3 R5 match = period
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             run, center, pol, dten, upd_dis, per_we, mat_we;
  logic [CNT_W-1:0] wdata;
  logic [DT_W-1:0]  dt_val;
  logic             out_a, out_b;

  int checks = 0;
  int errs   = 0;

  always #4 clk = ~clk;

  motor_pwm_chan #(.CNT_W(CNT_W), .DT_W(DT_W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .center_i  (center),
    .pol_i     (pol),
    .dt_en_i   (dten),
    .upd_dis_i (upd_dis),
    .per_we_i  (per_we),
    .mat_we_i  (mat_we),
    .wdata_i   (wdata),
    .dt_val_i  (dt_val),
    .out_a_o   (out_a),
    .out_b_o   (out_b)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_per(input int v);
    @(negedge clk); per_we = 1'b1; wdata = CNT_W'(v);
    @(negedge clk); per_we = 1'b0;
  endtask

  task automatic wr_mat(input int v);
    @(negedge clk); mat_we = 1'b1; wdata = CNT_W'(v);
    @(negedge clk); mat_we = 1'b0;
  endtask

  // counts active clocks on each output (pol decoded) over n clocks
  task automatic measure(input int n, output int ca, output int cb, output int ov);
    ca = 0; cb = 0; ov = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_a ^ pol) ca++;
      if (out_b ^ pol) cb++;
      if ((out_a ^ pol) && (out_b ^ pol)) ov++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    int ca, cb, ov, len;
    run = 0; center = 0; pol = 0; dten = 0; upd_dis = 0;
    per_we = 0; mat_we = 0; wdata = '0; dt_val = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10: reset state, passive outputs
    @(negedge clk);
    check("R10 out_a after reset", int'(out_a), 0);
    check("R10 out_b after reset", int'(out_b), 0);
    // R5: passive is high with pol=1 while stopped
    pol = 1'b1;
    @(negedge clk);
    check("R5 out_a passive high", int'(out_a), 1);
    check("R5 out_b passive high", int'(out_b), 1);
    pol = 1'b0;

    foreach (VECS[k]) begin
      @(negedge clk);
      run = 1'b0;
      center = VECS[k].center; pol = VECS[k].pol; dten = VECS[k].dten;
      dt_val = VECS[k].dt; upd_dis = 1'b0;
      wr_per(int'(VECS[k].per));
      wr_mat(int'(VECS[k].mat));
      @(negedge clk); run = 1'b1;
      len = VECS[k].center ? 2 * int'(VECS[k].per) : int'(VECS[k].per) + 1;
      repeat (3 * len + int'(VECS[k].dt) + 4) @(negedge clk);
      measure(NPER * len, ca, cb, ov);
      check($sformatf("R2/R3/R6 vec%0d A active", k), ca, NPER * int'(VECS[k].exp_a));
      check($sformatf("R4/R6 vec%0d B active", k), cb, NPER * int'(VECS[k].exp_b));
      check($sformatf("R6 vec%0d overlap", k), ov, 0);
    end

    // R1: stop forces passive levels and they hold
    @(negedge clk); run = 1'b0; pol = 1'b0; dten = 1'b0; center = 1'b0;
    @(negedge clk);
    measure(20, ca, cb, ov);
    check("R1 A passive while stopped", ca, 0);
    check("R1 B passive while stopped", cb, 0);

    // R7: running writes load at end of cycle
    wr_per(9); wr_mat(4);
    @(negedge clk); run = 1'b1;
    repeat (30) @(negedge clk);
    wr_mat(8);
    wr_per(11);
    repeat (40) @(negedge clk);
    measure(3 * 12, ca, cb, ov);
    check("R7 A after shadow load", ca, 3 * 4);
    check("R7 B after shadow load", cb, 3 * 8);

    // R8: frozen while running
    @(negedge clk); upd_dis = 1'b1;
    wr_mat(2);
    repeat (40) @(negedge clk);
    measure(3 * 12, ca, cb, ov);
    check("R8 A unchanged while frozen", ca, 3 * 4);
    check("R8 B unchanged while frozen", cb, 3 * 8);

    // R9: stopped write bypasses freeze
    @(negedge clk); run = 1'b0;
    wr_mat(5);
    @(negedge clk); run = 1'b1;
    repeat (40) @(negedge clk);
    measure(3 * 12, ca, cb, ov);
    check("R9 A after stopped write", ca, 3 * 7);
    check("R9 B after stopped write", cb, 3 * 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule